// File: doc/BRIEF.md
# Counter Channel Glue with Latched Terminal-Count Interrupts

This block surrounds three 16-bit down-counter channels (numbered 3, 4 and 5) with the control and interrupt logic a host needs. A control register sets the gate level of each channel and picks, for channels 3 and 4, between an internal tick and an external clock pin. A mode bit chains channels 3 and 4 into one 32-bit counter. The internal tick comes from dividing the bus clock by a parameter, which is 8 by default. With a 33.33 MHz bus clock this gives about 4.167 MHz.

Every channel's terminal count sets a sticky flag in a status register. The host reads the flags back and clears each one by writing a 1 to its bit. An enable register masks the flags, and the enabled flags are ORed into a single interrupt line. The two external clock pins are synchronized and edge-detected before they can advance a counter. A global external-clock enable input also qualifies them. The counter modes themselves are out of scope. Plain reload down-counters with parameter reload values stand in for them.

Top module: `tmr_glue_top`

## Requirements
- R1: After reset the control register, the enable register and all three flags read as 0, and `irq` is 0.
- R2: The host port is byte wide and decodes `addr` as follows.
  - Address 0 is the control register. Its bits are: bit 0 gate 3, bit 1 gate 4, bit 2 gate 5, bit 3 external select 3, bit 4 external select 4, bit 5 cascade. Bits 7:6 read 0.
  - Address 2 is the enable register in bits 2:0.
  - Address 3 reads 0.
  - A write with `wr_en` high updates the addressed register at that clock edge.
- R3: Each counter advances only on a tick while its gate bit is 1. It counts down from its reload value and returns to that value on a tick at 0. A tick at 0 sets the channel's flag at that same edge, so the period is reload+1 ticks.
- R4: The internal tick is high on one cycle in every DIV cycles. The first internal tick after reset acts at the DIV-th rising edge.
- R5: With its external select bit at 1, a channel takes its ticks from a rising edge of its pin, qualified by `ext_en`. The pin is sampled at each edge. If it is low at edge k-1 and high at edge k, the counter steps at edge k+2, provided `ext_en` is high in the cycle before that edge.
- R6: Address 1 reads the flags in bits 2:0, with bit 2 for channel 5, bit 1 for channel 4 and bit 0 for channel 3. Bits 7:3 read 0. Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it unchanged.
- R7: A flag that is set and cleared at the same edge ends up set.
- R8: With cascade at 1, channel 3 runs from its own clock choice and gate. Channel 4 steps only when channel 3 wraps and gate 4 is 1. Only channel 4's terminal count sets flag 1, channel 3 sets no flag, and external select 4 has no effect.
- R9: `irq` is high exactly when some flag is 1 while its bit in the enable register is 1.
- R10: Channel 5 always runs from the internal tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data of the selected register |
| ext_en | input | 1 | Qualifier for both external clock pins |
| ext_clk3 | input | 1 | External clock pin for channel 3 |
| ext_clk4 | input | 1 | External clock pin for channel 4 |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench targets four corner cases.
- A write-one clear issued on every cycle while a channel keeps reaching terminal count. This forces set/clear collisions; a design where clear wins would drop the event and show a flag that never reads 1.
- Cascade mode runs long enough for several upper terminal counts. A design that stepped the upper counter on every tick, or let the lower wrap raise flag 0, would show flags at the wrong cycles.
- External pins are toggled with `ext_en` both high and low. A missing synchronizer stage moves every step one cycle early, and an ignored qualifier counts edges that should be dropped.
- Reserved bits and the unused address are written with all ones. An incorrect decode would read those bits back as 1.

// File: rtl/tmr_glue_pkg.sv
package tmr_glue_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_IEN  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic cascade;
    logic ext4;
    logic ext3;
    logic gate5;
    logic gate4;
    logic gate3;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
  localparam int NCH    = 3;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int W      = 16,
  parameter int RELOAD = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic         tc_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] RLD = W'(RELOAD);

  logic [W-1:0] cnt_q, cnt_nxt;

  assign tc_o = step_i && (cnt_q == '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (step_i) cnt_nxt = (cnt_q == '0) ? RLD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RLD;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R3
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && cnt_q == '0) |=> (cnt_q == RLD));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_nxt;

  always_comb begin
    flag_nxt = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_nxt;
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/tmr_glue_top.sv
module tmr_glue_top
  import tmr_glue_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV         = 8,
  parameter int RELOAD3     = 3,
  parameter int RELOAD4     = 2,
  parameter int RELOAD5     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_en,
  input  logic       ext_clk3,
  input  logic       ext_clk4,
  output logic       irq
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  reg_addr_e sel;
  assign sel = reg_addr_e'(addr);

  // host registers
  tmr_ctrl_t      ctrl_q, ctrl_nxt;
  logic [NCH-1:0] ien_q, ien_nxt;

  always_comb begin
    ctrl_nxt = ctrl_q;
    ien_nxt  = ien_q;
    if (wr_en && sel == ADDR_CTRL) ctrl_nxt = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    if (wr_en && sel == ADDR_IEN)  ien_nxt  = wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      ien_q  <= ien_nxt;
    end
  end

  // internal tick divider
  logic [DIV_W-1:0] div_q, div_nxt;
  logic             int_tick;

  assign int_tick = (div_q == DIV_LAST);

  always_comb begin
    div_nxt = int_tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nxt;
  end

  // external pin conditioning
  logic [1:0] pins, rise;
  assign pins = {ext_clk4, ext_clk3};

  for (genvar p = 0; p < 2; p++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins[p]),
      .rise_o (rise[p])
    );
  end

  // step selection
  logic src3, src4, step3, step4, step5;
  logic tc3, tc4, tc5;
  logic [CNT_W-1:0] cnt3, cnt4, cnt5;

  always_comb begin
    src3  = ctrl_q.ext3 ? (rise[0] & ext_en) : int_tick;
    src4  = ctrl_q.ext4 ? (rise[1] & ext_en) : int_tick;
    step3 = src3 & ctrl_q.gate3;
    step4 = ctrl_q.cascade ? (tc3 & ctrl_q.gate4) : (src4 & ctrl_q.gate4);
    step5 = int_tick & ctrl_q.gate5;
  end

  tmr_down_cnt #(.W(CNT_W), .RELOAD(RELOAD3)) u_cnt3 (
    .clk (clk), .rst_n (rst_n), .step_i (step3), .tc_o (tc3), .cnt_o (cnt3));
  tmr_down_cnt #(.W(CNT_W), .RELOAD(RELOAD4)) u_cnt4 (
    .clk (clk), .rst_n (rst_n), .step_i (step4), .tc_o (tc4), .cnt_o (cnt4));
  tmr_down_cnt #(.W(CNT_W), .RELOAD(RELOAD5)) u_cnt5 (
    .clk (clk), .rst_n (rst_n), .step_i (step5), .tc_o (tc5), .cnt_o (cnt5));

  // flags
  logic [NCH-1:0] flag_set, flag_clr, flags;

  always_comb begin
    flag_set = {tc5, tc4, tc3 & ~ctrl_q.cascade};
    flag_clr = (wr_en && sel == ADDR_STAT) ? wr_data[NCH-1:0] : '0;
  end

  tmr_flag_reg #(.N(NCH)) u_flags (
    .clk (clk), .rst_n (rst_n), .set_i (flag_set), .clr_i (flag_clr), .flag_o (flags));

  assign irq = |(flags & ien_q);

  always_comb begin
    unique case (sel)
      ADDR_CTRL: rd_data = {{(8-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: rd_data = {{(8-NCH){1'b0}}, flags};
      ADDR_IEN:  rd_data = {{(8-NCH){1'b0}}, ien_q};
      default:   rd_data = 8'h00;
    endcase
  end

  // R8
  cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.cascade && !tc3) |=> $stable(cnt4));
  // R5
  ext_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ext3 && !ext_en) |=> $stable(cnt3));
  // R3
  gate5_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.gate5 |=> $stable(cnt5));
  // R8
  no_flag3_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.cascade && !flags[0] && !wr_en) |=> !flags[0]);
endmodule

// File: tb/tb_tmr_glue_top.sv
module tb_tmr_glue_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int RL3 = 3, RL4 = 2, RL5 = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wr_data = 8'h00;
  logic       ext_en = 1'b0;
  logic       ext_clk3 = 1'b0;
  logic       ext_clk4 = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_glue_top #(.DIV(DIV), .RELOAD3(RL3), .RELOAD4(RL4), .RELOAD5(RL5)) dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wr_data (wr_data),
    .rd_data (rd_data), .ext_en (ext_en), .ext_clk3 (ext_clk3), .ext_clk4 (ext_clk4),
    .irq (irq));

  // behavioural reference
  int   m_div, m_c3, m_c4, m_c5;
  bit [2:0] m_flags, m_ien;
  bit [5:0] m_ctrl;
  bit [1:0] m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_c3 = RL3; m_c4 = RL4; m_c5 = RL5;
      m_flags = 0; m_ien = 0; m_ctrl = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit itick, r3, r4, st3, st4, st5, t3, t4, t5;
      bit [2:0] setv, clrv;
      itick = (m_div == DIV-1);
      r3 = m_s2[0] && !m_s3[0];
      r4 = m_s2[1] && !m_s3[1];
      st3 = (m_ctrl[3] ? (r3 && ext_en) : itick) && m_ctrl[0];
      t3  = st3 && (m_c3 == 0);
      if (m_ctrl[5]) st4 = t3 && m_ctrl[1];
      else           st4 = (m_ctrl[4] ? (r4 && ext_en) : itick) && m_ctrl[1];
      t4  = st4 && (m_c4 == 0);
      st5 = itick && m_ctrl[2];
      t5  = st5 && (m_c5 == 0);
      setv = {t5, t4, t3 && !m_ctrl[5]};
      clrv = (wr_en && addr == 2'd1) ? wr_data[2:0] : 3'b0;
      m_flags = (m_flags & ~clrv) | setv;
      if (st3) m_c3 = (m_c3 == 0) ? RL3 : m_c3 - 1;
      if (st4) m_c4 = (m_c4 == 0) ? RL4 : m_c4 - 1;
      if (st5) m_c5 = (m_c5 == 0) ? RL5 : m_c5 - 1;
      m_div = itick ? 0 : m_div + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = {ext_clk4, ext_clk3};
      if (wr_en && addr == 2'd0) m_ctrl = wr_data[5:0];
      if (wr_en && addr == 2'd2) m_ien  = wr_data[2:0];
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s: actual %02h expected %02h at %0t", phase, tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      case (addr)
        2'd0: exp_rd = {2'b00, m_ctrl};
        2'd1: exp_rd = {5'b0, m_flags};
        2'd2: exp_rd = {5'b0, m_ien};
        default: exp_rd = 8'h00;
      endcase
      check(addr == 2'd1 ? "R6" : "R2", rd_data, exp_rd);
      check("R9", {7'b0, irq}, {7'b0, |(m_flags & m_ien)});
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0; addr = 2'd1; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1: reset values of every register and irq
    phase = "R1";
    for (int a = 0; a < 4; a++) begin
      @(posedge clk); #2; addr = 2'(a);
      @(negedge clk); check("R1", rd_data, 8'h00);
    end
    addr = 2'd1;
    // R2: reserved control bits and unused address read zero
    phase = "R2";
    wr(2'd0, 8'hFF);
    addr = 2'd0; cyc(1); addr = 2'd3; cyc(1); addr = 2'd1;
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    // R3 R4 R10: internal ticks on gated channels 3 and 5
    phase = "R3";
    wr(2'd0, 8'h05);
    cyc(80);
    phase = "R10";
    wr(2'd0, 8'h14); // gate5 with ext4 select only affecting channel 4
    cyc(60);
    // R6: write-one clear and write-zero no effect
    phase = "R6";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h05);
    cyc(4);
    // R7: clear every cycle while events keep arriving
    phase = "R7";
    wr(2'd0, 8'h07);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = 2'd1; wr_data = 8'h07;
    cyc(70);
    wr_en = 1'b0; wr_data = 8'h00;
    cyc(4);
    // R9: enable mask variants
    phase = "R9";
    wr(2'd2, 8'h01); cyc(30);
    wr(2'd2, 8'h04); cyc(30);
    wr(2'd2, 8'h00); cyc(20);
    wr(2'd2, 8'h07);
    // R5: external pins with qualifier high and low
    phase = "R5";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h1B);
    ext_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      ext_clk3 = ~ext_clk3; cyc(1);
      if (k % 3 == 0) ext_clk4 = ~ext_clk4;
      cyc(1);
      if (k == 20) ext_en = 1'b0;
      if (k == 30) ext_en = 1'b1;
    end
    cyc(5);
    // R8: cascade with channel 3 internal, ext4 select ignored
    phase = "R8";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h33);
    for (int k = 0; k < 120; k++) begin
      ext_clk4 = ~ext_clk4; cyc(2);
    end
    wr(2'd1, 8'h07);
    // R8: cascade with channel 3 on its external pin
    wr(2'd0, 8'h2B);
    for (int k = 0; k < 60; k++) begin
      ext_clk3 = ~ext_clk3; cyc(2);
    end
    cyc(5);
    finish_run();
  end
endmodule